// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block turns the event signals of a deep-FIFO UART into a single interrupt request and a set of identification bits. Five sources can raise it: receive data reaching a trigger level, a character timeout, transmit space reaching a trigger level, a receive line error, and a change on the modem input lines. Any number of these bits can be set at the same time. Software reads them and clears the ones it has handled by writing ones to them. Writing a zero leaves a bit as it is.

The receive and transmit trigger levels are 3-bit codes taken from the configuration word. Code n means a threshold of 2^(n+2) bytes, so the codes cover 4 to 512 bytes on a 1024-entry FIFO. The modem inputs are sampled on each clock. Changes on CTS, DSR and DCD, and a falling edge on RI, set sticky delta bits. These delta bits are cleared together with the modem identification bit. The FIFO storage and the serializer are outside this block. It receives only their fill counts and event pulses.

Top module: `uart_irq_ident`

## Requirements
- R1: During and right after reset, `irq_id` is 0, `irq` is 0 and `modem_sts` is 0.
- R2: With receive enable `cfg_word[0]` set, `irq_id[1]` is set on the clock edge at which `rx_count >= 2^(rx_lvl+2)`, where `rx_lvl = cfg_word[22:20]`.
- R3: With transmit enable `cfg_word[1]` set, `irq_id[3]` is set on the clock edge at which `DEPTH - tx_count >= 2^(tx_lvl+2)`, where `tx_lvl = cfg_word[18:16]`.
- R4: With `cfg_word[0]` set, a one-cycle `rx_tmo` pulse sets `irq_id[2]` on that edge.
- R5: With line enable `cfg_word[2]` set, `irq_id[0]` is set when any of the bits 1, 2, 3, 4 or 7 of `line_sts` is high. These are overrun, parity, framing, break and receive FIFO error. Bits 0, 5 and 6 have no effect.
- R6: `modem_sts[7:4]` holds the sampled levels of `modem_in`, with bit 0 = CTS, bit 1 = DSR, bit 2 = RI and bit 3 = DCD. `modem_sts[3:0]` holds sticky deltas in the same order. The RI delta is set only on a 1-to-0 edge. With `cfg_word[3]` set, a nonzero delta sets `irq_id[4]` on the following edge.
- R7: A cycle with `sts_wr` high clears on that edge every `irq_id` bit whose `sts_wdata` bit is 1 and leaves the other bits alone. Clearing bit 4 also clears `modem_sts[3:0]`, unless a new edge arrives in the same cycle.
- R8: A cause that is still present when its bit is cleared sets the bit again on the next edge.
- R9: A cause whose enable is 0 does not set its `irq_id` bit.
- R10: `irq` is the OR of the `irq_id` bits whose enables are set. The mapping is: bit 0 to `cfg_word[2]`, bits 1 and 2 to `cfg_word[0]`, bit 3 to `cfg_word[1]` and bit 4 to `cfg_word[3]`. Clearing an enable masks `irq` but keeps the bit.
- R11: Several causes present in the same cycle set their bits together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 32 | Configuration word: enables [3:0], transmit level [18:16], receive level [22:20] |
| rx_count | input | CNT_W (11) | Receive FIFO fill count |
| tx_count | input | CNT_W (11) | Transmit FIFO fill count |
| rx_tmo | input | 1 | Character-timeout pulse from the receive path |
| line_sts | input | 8 | Line status byte from the receiver |
| modem_in | input | 4 | Modem inputs {DCD, RI, DSR, CTS} |
| sts_wr | input | 1 | Write strobe for the identification byte |
| sts_wdata | input | 8 | Write data; ones in [4:0] clear identification bits |
| irq | output | 1 | Interrupt request |
| irq_id | output | 5 | Latched identification bits |
| modem_sts | output | 8 | Modem levels [7:4] and sticky deltas [3:0] |

## Verification
Fill counts are applied at exactly the threshold and one byte short of it. This is done for the lowest, middle and highest level codes on both FIFOs, so an off-by-one or a wrong shift in the threshold is exposed. Line status is driven once with only the non-error bits high and once with a single error bit. Modem lines are driven with a rising RI, a falling RI and a DCD edge, which separates the trailing-edge rule from the plain change rule. Clears are exercised as a full clear, a partial clear with another bit still pending, and a clear while the cause persists, so the write-one-to-clear and the re-latch behaviour are each seen on their own.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int ID_W      = 5;
  localparam int EN_W      = 4;
  localparam int LVL_W     = 3;
  localparam int MDM_W     = 4;

  // identification bit positions (software decodes these)
  localparam int ID_LINE    = 0;
  localparam int ID_RXDATA  = 1;
  localparam int ID_RXTMO   = 2;
  localparam int ID_TXSPACE = 3;
  localparam int ID_MODEM   = 4;

  // enable bit positions in the configuration word
  localparam int EN_RX    = 0;
  localparam int EN_TX    = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;

  localparam int TXLVL_LSB = 16;
  localparam int RXLVL_LSB = 20;

  // line status bits that count as errors: overrun, parity, framing, break, fifo error
  localparam logic [7:0] LINE_ERR_MASK = 8'b1001_1110;

  typedef struct packed {
    logic [EN_W-1:0]  en;
    logic [LVL_W-1:0] tx_lvl;
    logic [LVL_W-1:0] rx_lvl;
  } irq_cfg_t;

  function automatic irq_cfg_t decode_cfg(input logic [31:0] w);
    irq_cfg_t c;
    c.en     = w[EN_W-1:0];
    c.tx_lvl = w[TXLVL_LSB +: LVL_W];
    c.rx_lvl = w[RXLVL_LSB +: LVL_W];
    return c;
  endfunction

  // trigger level code -> byte threshold: 4 << code
  function automatic int unsigned lvl_bytes(input logic [LVL_W-1:0] lvl);
    return 32'd4 << lvl;
  endfunction

  // spread the four enables over the five identification bits
  function automatic logic [ID_W-1:0] en_to_id(input logic [EN_W-1:0] en);
    logic [ID_W-1:0] m;
    m[ID_LINE]    = en[EN_LINE];
    m[ID_RXDATA]  = en[EN_RX];
    m[ID_RXTMO]   = en[EN_RX];
    m[ID_TXSPACE] = en[EN_TX];
    m[ID_MODEM]   = en[EN_MODEM];
    return m;
  endfunction
endpackage

// File: rtl/irq_level_cmp.sv
module irq_level_cmp
  import uart_irq_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_lvl,
  input  logic [LVL_W-1:0] tx_lvl,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_count,
  output logic             rx_hit,
  output logic             tx_hit
);
  logic [CNT_W-1:0] rx_thr, tx_thr, tx_free;

  always_comb begin
    rx_thr  = CNT_W'(lvl_bytes(rx_lvl));
    tx_thr  = CNT_W'(lvl_bytes(tx_lvl));
    tx_free = CNT_W'(DEPTH) - tx_count;
    rx_hit  = (rx_count >= rx_thr);
    tx_hit  = (tx_free >= tx_thr);
  end

  // R2
  rx_empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == '0) |-> !rx_hit);

  // R3
  tx_full_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == CNT_W'(DEPTH)) |-> !tx_hit);
endmodule

// File: rtl/irq_modem_delta.sv
module irq_modem_delta
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MDM_W-1:0] modem_in,
  input  logic             clr,
  output logic [MDM_W-1:0] delta,
  output logic [MDM_W-1:0] level
);
  logic             primed;
  logic [MDM_W-1:0] edge_seen;

  // bit 2 (RI) reacts only to a falling edge, others to any change
  always_comb begin
    edge_seen = '0;
    if (primed) begin
      for (int i = 0; i < MDM_W; i++)
        edge_seen[i] = (i == 2) ? (level[i] & ~modem_in[i])
                                : (level[i] ^ modem_in[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed <= 1'b0;
      level  <= '0;
      delta  <= '0;
    end else begin
      primed <= 1'b1;
      level  <= modem_in;
      delta  <= (clr ? '0 : delta) | edge_seen;
    end
  end

  // R7
  delta_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && primed && modem_in == level) |=> (delta == '0));
endmodule

// File: rtl/irq_cause_latch.sv
module irq_cause_latch
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ID_W-1:0] set_req,
  input  logic            clr_wr,
  input  logic [ID_W-1:0] clr_mask,
  input  logic [ID_W-1:0] en_id,
  output logic [ID_W-1:0] id,
  output logic            irq
);
  logic [ID_W-1:0] clr_eff;

  assign clr_eff = clr_wr ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) id <= '0;
    else        id <= (id | set_req) & ~clr_eff;
  end

  assign irq = |(id & en_id);

  // R7
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((id & $past(clr_mask)) == '0));

  // R11
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((id & $past(id)) == $past(id)));

  // R8
  set_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_wr && set_req != '0) |=> ((id & $past(set_req)) == $past(set_req)));

  // R10
  mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_id == '0) |-> !irq);
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      cfg_word,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_count,
  input  logic             rx_tmo,
  input  logic [7:0]       line_sts,
  input  logic [3:0]       modem_in,
  input  logic             sts_wr,
  input  logic [7:0]       sts_wdata,
  output logic             irq,
  output logic [4:0]       irq_id,
  output logic [7:0]       modem_sts
);
  irq_cfg_t        cfg;
  logic            rx_hit, tx_hit, line_hit, modem_hit, clr_modem;
  logic [MDM_W-1:0] m_delta, m_level;
  logic [ID_W-1:0] set_req, en_id;
  logic            unused_bits;

  assign cfg         = decode_cfg(cfg_word);
  assign en_id       = en_to_id(cfg.en);
  assign unused_bits = ^{cfg_word[31:23], cfg_word[19], cfg_word[15:4], sts_wdata[7:5]};

  irq_level_cmp #(.DEPTH(DEPTH)) u_lvl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_lvl   (cfg.rx_lvl),
    .tx_lvl   (cfg.tx_lvl),
    .rx_count (rx_count),
    .tx_count (tx_count),
    .rx_hit   (rx_hit),
    .tx_hit   (tx_hit)
  );

  assign clr_modem = sts_wr & sts_wdata[ID_MODEM];

  irq_modem_delta u_mdm (
    .clk      (clk),
    .rst_n    (rst_n),
    .modem_in (modem_in),
    .clr      (clr_modem),
    .delta    (m_delta),
    .level    (m_level)
  );

  assign line_hit  = |(line_sts & LINE_ERR_MASK);
  assign modem_hit = |m_delta;

  always_comb begin
    set_req             = '0;
    set_req[ID_LINE]    = line_hit  & cfg.en[EN_LINE];
    set_req[ID_RXDATA]  = rx_hit    & cfg.en[EN_RX];
    set_req[ID_RXTMO]   = rx_tmo    & cfg.en[EN_RX];
    set_req[ID_TXSPACE] = tx_hit    & cfg.en[EN_TX];
    set_req[ID_MODEM]   = modem_hit & cfg.en[EN_MODEM];
  end

  irq_cause_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_req  (set_req),
    .clr_wr   (sts_wr),
    .clr_mask (sts_wdata[ID_W-1:0]),
    .en_id    (en_id),
    .id       (irq_id),
    .irq      (irq)
  );

  assign modem_sts = {m_level, m_delta};

  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.en == '0 && irq_id == '0) |=> (irq_id == '0));
endmodule

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
  localparam int DEPTH = 1024;
  localparam int CNT_W = $clog2(DEPTH) + 1;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [31:0]      cfg_word;
  logic [CNT_W-1:0] rx_count, tx_count;
  logic             rx_tmo;
  logic [7:0]       line_sts;
  logic [3:0]       modem_in;
  logic             sts_wr;
  logic [7:0]       sts_wdata;
  logic             irq;
  logic [4:0]       irq_id;
  logic [7:0]       modem_sts;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  uart_irq_ident #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .rx_count(rx_count),
    .tx_count(tx_count), .rx_tmo(rx_tmo), .line_sts(line_sts),
    .modem_in(modem_in), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
    .irq(irq), .irq_id(irq_id), .modem_sts(modem_sts)
  );

  // {rx_lvl, rx_count, tx_lvl, tx_count, exp rx-data bit, exp tx-space bit}
  localparam logic [29:0] VEC [0:5] = '{
    {3'd0, 11'd3,    3'd0, 11'd1020, 1'b0, 1'b1},
    {3'd0, 11'd4,    3'd0, 11'd1021, 1'b1, 1'b0},
    {3'd5, 11'd127,  3'd5, 11'd896,  1'b0, 1'b1},
    {3'd5, 11'd128,  3'd5, 11'd897,  1'b1, 1'b0},
    {3'd7, 11'd1024, 3'd7, 11'd512,  1'b1, 1'b1},
    {3'd6, 11'd255,  3'd7, 11'd513,  1'b0, 1'b0}
  };

  function automatic logic [31:0] mk_cfg(input logic [3:0] en, input logic [2:0] rxl,
                                         input logic [2:0] txl);
    return {9'd0, rxl, 1'b0, txl, 12'd0, en};
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic neutral_clear();
    rx_count = '0; tx_count = CNT_W'(DEPTH); rx_tmo = 1'b0; line_sts = 8'h00;
    sts_wr = 1'b1; sts_wdata = 8'h1f;
    tick();
    sts_wr = 1'b0; sts_wdata = 8'h00;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_word = '0; rx_count = '0; tx_count = CNT_W'(DEPTH);
    rx_tmo = 1'b0; line_sts = '0; modem_in = '0; sts_wr = 1'b0; sts_wdata = '0;
    #1;
    repeat (3) tick();
    chk("R1 id in reset", 32'(irq_id), 32'h0);
    chk("R1 irq in reset", 32'(irq), 32'h0);
    rst_n = 1'b1;
    tick();
    chk("R1 id after reset", 32'(irq_id), 32'h0);
    chk("R1 modem_sts after reset", 32'(modem_sts), 32'h0);

    // R2 / R3 threshold table
    for (int v = 0; v < 6; v++) begin
      cfg_word = mk_cfg(4'b0011, VEC[v][29:27], VEC[v][15:13]);
      rx_count = VEC[v][26:16];
      tx_count = VEC[v][12:2];
      tick();
      chk($sformatf("R2 vec%0d rx-data bit", v), 32'(irq_id[1]), 32'(VEC[v][1]));
      chk($sformatf("R3 vec%0d tx-space bit", v), 32'(irq_id[3]), 32'(VEC[v][0]));
      chk($sformatf("R10 vec%0d irq", v), 32'(irq), 32'(VEC[v][1] | VEC[v][0]));
      neutral_clear();
      chk($sformatf("R7 vec%0d full clear", v), 32'(irq_id), 32'h0);
    end

    // R4 character timeout
    cfg_word = mk_cfg(4'b0001, 3'd7, 3'd7);
    rx_tmo = 1'b1; tick(); rx_tmo = 1'b0;
    chk("R4 timeout bit", 32'(irq_id), 32'h04);
    chk("R4 irq", 32'(irq), 32'h1);
    tick();
    chk("R4 timeout sticky", 32'(irq_id), 32'h04);
    neutral_clear();

    // R5 line status
    cfg_word = mk_cfg(4'b0100, 3'd7, 3'd7);
    line_sts = 8'h01; tick();
    chk("R5 data-ready only", 32'(irq_id), 32'h0);
    line_sts = 8'h60; tick();
    chk("R5 tx-empty bits only", 32'(irq_id), 32'h0);
    line_sts = 8'h08; tick();
    chk("R5 framing error", 32'(irq_id), 32'h01);
    neutral_clear();

    // R9 all causes present but disabled
    cfg_word = mk_cfg(4'b0000, 3'd0, 3'd0);
    rx_count = CNT_W'(DEPTH); tx_count = '0; rx_tmo = 1'b1; line_sts = 8'h02;
    tick(); rx_tmo = 1'b0;
    tick();
    chk("R9 disabled id", 32'(irq_id), 32'h0);
    chk("R9 disabled irq", 32'(irq), 32'h0);
    neutral_clear();

    // R11 simultaneous, R8 re-latch, partial clear, R10 masking
    cfg_word = mk_cfg(4'b0111, 3'd0, 3'd7);
    rx_count = 11'd4; line_sts = 8'h10;
    tick();
    chk("R11 two bits together", 32'(irq_id), 32'h03);
    sts_wr = 1'b1; sts_wdata = 8'h03; tick(); sts_wr = 1'b0; sts_wdata = 8'h00;
    chk("R7 cleared while cause held", 32'(irq_id), 32'h0);
    tick();
    chk("R8 re-latched", 32'(irq_id), 32'h03);
    rx_count = '0; line_sts = 8'h00;
    sts_wr = 1'b1; sts_wdata = 8'h01; tick(); sts_wr = 1'b0; sts_wdata = 8'h00;
    chk("R7 partial clear keeps bit1", 32'(irq_id), 32'h02);
    cfg_word = mk_cfg(4'b0000, 3'd0, 3'd7); #1;
    chk("R10 masked irq", 32'(irq), 32'h0);
    chk("R10 bit kept when masked", 32'(irq_id), 32'h02);
    cfg_word = mk_cfg(4'b0001, 3'd0, 3'd7); #1;
    chk("R10 unmasked irq", 32'(irq), 32'h1);
    neutral_clear();

    // R6 modem deltas
    cfg_word = mk_cfg(4'b1000, 3'd7, 3'd7);
    modem_in = 4'b0001; tick();
    chk("R6 cts delta", 32'(modem_sts), 32'h11);
    tick();
    chk("R6 modem id", 32'(irq_id), 32'h10);
    chk("R6 modem irq", 32'(irq), 32'h1);
    sts_wr = 1'b1; sts_wdata = 8'h10; tick(); sts_wr = 1'b0; sts_wdata = 8'h00;
    chk("R7 modem clear id", 32'(irq_id), 32'h0);
    chk("R7 modem deltas cleared", 32'(modem_sts), 32'h10);
    modem_in = 4'b0101; tick(); tick();
    chk("R6 ri rise no delta", 32'(modem_sts), 32'h50);
    chk("R6 ri rise no id", 32'(irq_id), 32'h0);
    modem_in = 4'b0001; tick();
    chk("R6 ri fall delta", 32'(modem_sts), 32'h14);
    tick();
    chk("R6 ri fall id", 32'(irq_id), 32'h10);
    sts_wr = 1'b1; sts_wdata = 8'h10; tick(); sts_wr = 1'b0; sts_wdata = 8'h00;
    modem_in = 4'b1001; tick();
    chk("R6 dcd delta", 32'(modem_sts), 32'h98);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule